// File: doc/BRIEF.md
# Partial Region Controller

This block supervises the hardware tasks that live in a set of reconfigurable regions. Each region has its own state machine and its own small group of registers, all reached through one memory-mapped AXI4-Lite slave port. Software uses the registers to issue start, reload and stop commands, to set a region's three working arguments and its post-reload reset length, and to read the region's state and pending events.

A reload request never cuts a data frame short. The region first stops taking new frames. It then waits until the frame in flight has finished and its pipeline is empty. Only then does it offer itself to the reconfiguration engine and raise a ready event. The engine's done pulse starts a reset of programmable length. When the reset ends, the new task starts by itself. Each region drives one interrupt line. The line is gated by an enable bit and stays high while any event bit of that region is pending.

Region slots are 32 bytes apart. Word 0 is the command/state word, word 1 is the region status, word 2 is the interrupt status, word 3 is the reset length, and words 4 to 6 are the arguments.

Top module: `prr_ctrl`

## Requirements
- R1: After reset every region is idle (state code 0). All region outputs are low, and every register reads 0 except region status, which reads 4 while the pipe-empty input is high.
- R2: The argument registers (words 4..6, offsets 0x10/0x14/0x18 in a slot) and the reset-length register (word 3, offset 0x0C) read back what was written, byte by byte under the write strobes. Argument k of region r appears on `arg_o[(r*3+k)*32 +: 32]`.
- R3: An access that is misaligned, that names word 7, a region past the last one, or any address bit above the slot index gets SLVERR (2'b10) and changes nothing; such reads return 0. Mapped accesses get OKAY.
- R4: Command bit 0 (start), written to word 0 of an idle region, moves it to running (code 1). `run_o` goes high and `start_o` pulses for exactly one cycle.
- R5: Command bit 1 (reload) in idle, running or active enters drain (code 2). In drain, `hold_o` is high, `run_o` stays high and `load_rdy_o` stays low for as long as the frame-busy input is high or the pipe-empty input is low.
- R6: When the frame-busy input is low and the pipe-empty input is high during drain, the region moves to reconfig (code 3) on the next edge. `load_rdy_o` goes high and interrupt-status bit 0 is set.
- R7: A done pulse in reconfig moves the region to reset (code 4). `rrst_o` is then high for exactly max(word 3, 4) cycles, and `run_o` is low throughout reconfig and reset.
- R8: When the reset ends, the region enters active (code 5) with no software action. `run_o` goes high, `start_o` pulses once and interrupt-status bit 1 is set.
- R9: A command that has more than one bit set, or that is illegal in the current state, leaves the state unchanged. It sets region-status bit 0 and interrupt-status bit 2. Start is legal only in idle, and stop only in running or active. No command is legal in drain, reconfig or reset.
- R10: Interrupt-status bits 2..0 are write-one-to-clear, and bit 8 is a plain read/write enable. Region-status bit 0 is also write-one-to-clear. `irq_o[r]` equals enable AND (any of bits 2..0).
- R11: Regions are independent. An access to one region does not change another region's state or registers.
- R12: Command bit 2 (stop) in running or active returns the region to idle and lowers `run_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | AW | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DW | Write data |
| s_wstrb | input | DW/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | AW | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DW | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| frame_busy_i | input | NREG | Region is inside a data frame |
| pipe_empty_i | input | NREG | Region pipeline holds no data |
| cfg_done_i | input | NREG | Reconfiguration engine finished loading the region |
| run_o | output | NREG | Region task enabled |
| hold_o | output | NREG | Region must not begin a new frame |
| load_rdy_o | output | NREG | Region may be reloaded |
| rrst_o | output | NREG | Reset to the reloaded region |
| start_o | output | NREG | One-cycle task start pulse |
| irq_o | output | NREG | Per-region interrupt |
| arg_o | output | NREG*3*DW | Working arguments of every region |

## Verification
The bench holds a reload while the frame is still in flight. It then releases the frame-busy input before the pipeline has emptied. A controller that gated on only one of the two would offer the region too early, and `load_rdy_o` would rise while data was still in flight. The reset length is measured with the register at 0 and at 6. A design that skipped the floor of 4 would produce a reset of 0 or 1 cycle, and one with an off-by-one counter would produce 5 or 7. Commands are sent in states where they are illegal, and one command has two bits set. A design that acted on these anyway would change state instead of raising the error bit. The write-one-to-clear interrupt bits are cleared while the enable is kept, so an enable-only or clear-on-any-write design would leave the interrupt line in the wrong state.

// File: rtl/prr_pkg.sv
`timescale 1ns/1ps
package prr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_DRAIN = 3'd2,
        ST_RECFG = 3'd3,
        ST_RST   = 3'd4,
        ST_ACT   = 3'd5
    } rstate_e;

    localparam int unsigned NARG     = 3;
    localparam int unsigned MIN_RST  = 4;
    localparam int unsigned SLOT_LSB = 5;

    localparam logic [2:0] WD_PROC  = 3'd0;
    localparam logic [2:0] WD_RSTAT = 3'd1;
    localparam logic [2:0] WD_IRQ   = 3'd2;
    localparam logic [2:0] WD_DLY   = 3'd3;
    localparam logic [2:0] WD_ARG0  = 3'd4;
    localparam logic [2:0] WD_LAST  = 3'd6;

    localparam int unsigned CMD_START  = 0;
    localparam int unsigned CMD_RELOAD = 1;
    localparam int unsigned CMD_STOP   = 2;

    localparam int unsigned EV_RDY = 0;
    localparam int unsigned EV_ACT = 1;
    localparam int unsigned EV_ERR = 2;
    localparam int unsigned IE_BIT = 8;

    localparam logic [1:0] RESP_OK     = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/prr_axil.sv
`timescale 1ns/1ps
module prr_axil
    import prr_pkg::*;
#(
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int NREG = 8,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DW-1:0]     s_wdata,
    input  logic [DW/8-1:0]   s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [AW-1:0]     s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DW-1:0]     s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [2:0]        wr_word,
    output logic [DW-1:0]     wr_data,
    output logic [DW/8-1:0]   wr_strb,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [2:0]        rd_word,
    input  logic [DW-1:0]     rd_data
);
    typedef struct packed {
        logic          bvalid;
        logic [1:0]    bresp;
        logic          rvalid;
        logic [1:0]    rresp;
        logic [DW-1:0] rdata;
    } bus_t;

    bus_t q, d;

    function automatic logic mapped(input logic [AW-1:0] a);
        logic ok;
        ok = (a[1:0] == 2'b00);
        ok = ok && ((a >> (SLOT_LSB + IDX_W)) == '0);
        ok = ok && (int'(a[SLOT_LSB +: IDX_W]) < NREG);
        ok = ok && (a[4:2] <= WD_LAST);
        return ok;
    endfunction

    logic wfire, rfire, whit, rhit;

    always_comb begin
        d         = q;
        s_awready = s_awvalid && s_wvalid && !q.bvalid;
        s_wready  = s_awready;
        s_arready = s_arvalid && !q.rvalid;
        wfire     = s_awready;
        rfire     = s_arready;
        whit      = mapped(s_awaddr);
        rhit      = mapped(s_araddr);

        wr_en   = wfire && whit;
        wr_idx  = s_awaddr[SLOT_LSB +: IDX_W];
        wr_word = s_awaddr[4:2];
        wr_data = s_wdata;
        wr_strb = s_wstrb;
        rd_idx  = s_araddr[SLOT_LSB +: IDX_W];
        rd_word = s_araddr[4:2];

        if (q.bvalid && s_bready) d.bvalid = 1'b0;
        if (wfire) begin
            d.bvalid = 1'b1;
            d.bresp  = whit ? RESP_OK : RESP_SLVERR;
        end
        if (q.rvalid && s_rready) d.rvalid = 1'b0;
        if (rfire) begin
            d.rvalid = 1'b1;
            d.rresp  = rhit ? RESP_OK : RESP_SLVERR;
            d.rdata  = rhit ? rd_data : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign s_bvalid = q.bvalid;
    assign s_bresp  = q.bresp;
    assign s_rvalid = q.rvalid;
    assign s_rresp  = q.rresp;
    assign s_rdata  = q.rdata;
endmodule

// File: rtl/prr_region.sv
`timescale 1ns/1ps
module prr_region
    import prr_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 8,
    localparam int SW = DW / 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [2:0]             wr_word,
    input  logic [DW-1:0]          wr_data,
    input  logic [SW-1:0]          wr_strb,
    input  logic [2:0]             rd_word,
    output logic [DW-1:0]          rd_data,
    input  logic                   frame_busy_i,
    input  logic                   pipe_empty_i,
    input  logic                   cfg_done_i,
    output logic                   run_o,
    output logic                   hold_o,
    output logic                   load_rdy_o,
    output logic                   rrst_o,
    output logic                   start_o,
    output logic                   irq_o,
    output logic [NARG*DW-1:0]     arg_o
);
    typedef struct packed {
        rstate_e                  st;
        logic [CW-1:0]            cnt;
        logic [CW-1:0]            dly;
        logic                     ill;
        logic [2:0]               isr;
        logic                     ie;
        logic                     start;
        logic [NARG-1:0][DW-1:0]  args;
    } reg_t;

    reg_t q, d;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] o,
                                            input logic [DW-1:0] n,
                                            input logic [SW-1:0] s);
        logic [DW-1:0] r;
        r = o;
        for (int b = 0; b < SW; b++)
            if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
        return r;
    endfunction

    logic       cmd_wr;
    logic [2:0] cmd;
    logic       cmd_ok;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        cmd_wr  = wr_en && (wr_word == WD_PROC);
        cmd     = wr_data[2:0];

        cmd_ok = 1'b0;
        if ($onehot(cmd)) begin
            if (cmd[CMD_START])
                cmd_ok = (q.st == ST_IDLE);
            else if (cmd[CMD_RELOAD])
                cmd_ok = (q.st == ST_IDLE) || (q.st == ST_RUN) || (q.st == ST_ACT);
            else
                cmd_ok = (q.st == ST_RUN) || (q.st == ST_ACT);
        end

        // software register writes; event sets below take priority
        if (wr_en) begin
            case (wr_word)
                WD_RSTAT: if (wr_data[0]) d.ill = 1'b0;
                WD_IRQ: begin
                    d.ie  = wr_data[IE_BIT];
                    d.isr = q.isr & ~wr_data[2:0];
                end
                WD_DLY:  d.dly = CW'(merge(DW'(q.dly), wr_data, wr_strb));
                default: begin
                    for (int k = 0; k < NARG; k++)
                        if (wr_word == WD_ARG0 + 3'(k))
                            d.args[k] = merge(q.args[k], wr_data, wr_strb);
                end
            endcase
        end

        case (q.st)
            ST_IDLE: begin
                if (cmd_wr && cmd_ok) begin
                    if (cmd[CMD_START]) begin
                        d.st    = ST_RUN;
                        d.start = 1'b1;
                    end else begin
                        d.st = ST_DRAIN;
                    end
                end
            end
            ST_RUN, ST_ACT: begin
                if (cmd_wr && cmd_ok)
                    d.st = cmd[CMD_RELOAD] ? ST_DRAIN : ST_IDLE;
            end
            ST_DRAIN: begin
                if (!frame_busy_i && pipe_empty_i) begin
                    d.st          = ST_RECFG;
                    d.isr[EV_RDY] = 1'b1;
                end
            end
            ST_RECFG: begin
                if (cfg_done_i) begin
                    d.st  = ST_RST;
                    d.cnt = (q.dly < CW'(MIN_RST)) ? CW'(MIN_RST) : q.dly;
                end
            end
            ST_RST: begin
                if (q.cnt <= CW'(1)) begin
                    d.st          = ST_ACT;
                    d.start       = 1'b1;
                    d.isr[EV_ACT] = 1'b1;
                end else begin
                    d.cnt = q.cnt - CW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (cmd_wr && (cmd != 3'b000) && !cmd_ok) begin
            d.ill         = 1'b1;
            d.isr[EV_ERR] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_word)
            WD_PROC:  rd_data = DW'(q.st);
            WD_RSTAT: rd_data = DW'({pipe_empty_i, frame_busy_i, q.ill});
            WD_IRQ: begin
                rd_data[2:0]   = q.isr;
                rd_data[IE_BIT] = q.ie;
            end
            WD_DLY:   rd_data = DW'(q.dly);
            default: begin
                for (int k = 0; k < NARG; k++)
                    if (rd_word == WD_ARG0 + 3'(k)) rd_data = q.args[k];
            end
        endcase
    end

    assign run_o      = (q.st == ST_RUN) || (q.st == ST_DRAIN) || (q.st == ST_ACT);
    assign hold_o     = (q.st == ST_DRAIN);
    assign load_rdy_o = (q.st == ST_RECFG);
    assign rrst_o     = (q.st == ST_RST);
    assign start_o    = q.start;
    assign irq_o      = q.ie && (|q.isr);
    assign arg_o      = q.args;
endmodule

// File: rtl/prr_ctrl.sv
`timescale 1ns/1ps
module prr_ctrl
    import prr_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 12,
    parameter int DW   = 32,
    parameter int CW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            s_awaddr,
    input  logic                     s_awvalid,
    output logic                     s_awready,
    input  logic [DW-1:0]            s_wdata,
    input  logic [DW/8-1:0]          s_wstrb,
    input  logic                     s_wvalid,
    output logic                     s_wready,
    output logic [1:0]               s_bresp,
    output logic                     s_bvalid,
    input  logic                     s_bready,
    input  logic [AW-1:0]            s_araddr,
    input  logic                     s_arvalid,
    output logic                     s_arready,
    output logic [DW-1:0]            s_rdata,
    output logic [1:0]               s_rresp,
    output logic                     s_rvalid,
    input  logic                     s_rready,
    input  logic [NREG-1:0]          frame_busy_i,
    input  logic [NREG-1:0]          pipe_empty_i,
    input  logic [NREG-1:0]          cfg_done_i,
    output logic [NREG-1:0]          run_o,
    output logic [NREG-1:0]          hold_o,
    output logic [NREG-1:0]          load_rdy_o,
    output logic [NREG-1:0]          rrst_o,
    output logic [NREG-1:0]          start_o,
    output logic [NREG-1:0]          irq_o,
    output logic [NREG*NARG*DW-1:0]  arg_o
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [2:0]       wr_word;
    logic [DW-1:0]    wr_data;
    logic [DW/8-1:0]  wr_strb;
    logic [IDX_W-1:0] rd_idx;
    logic [2:0]       rd_word;
    logic [DW-1:0]    rd_sel;
    logic [DW-1:0]    rd_vec [NREG];

    prr_axil #(.AW(AW), .DW(DW), .NREG(NREG)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_data(wr_data),
        .wr_strb(wr_strb), .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(rd_sel)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        prr_region #(.DW(DW), .CW(CW)) u_rg (
            .clk(clk), .rst_n(rst_n),
            .wr_en(wr_en && (int'(wr_idx) == r)),
            .wr_word(wr_word), .wr_data(wr_data), .wr_strb(wr_strb),
            .rd_word(rd_word), .rd_data(rd_vec[r]),
            .frame_busy_i(frame_busy_i[r]), .pipe_empty_i(pipe_empty_i[r]),
            .cfg_done_i(cfg_done_i[r]),
            .run_o(run_o[r]), .hold_o(hold_o[r]), .load_rdy_o(load_rdy_o[r]),
            .rrst_o(rrst_o[r]), .start_o(start_o[r]), .irq_o(irq_o[r]),
            .arg_o(arg_o[r*NARG*DW +: NARG*DW])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int r = 0; r < NREG; r++)
            if (int'(rd_idx) == r) rd_sel = rd_vec[r];
    end
endmodule

// File: rtl/prr_ctrl_chk.sv
`timescale 1ns/1ps
module prr_ctrl_chk #(
    parameter int NREG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            s_bvalid,
    input logic            s_bready,
    input logic            s_rvalid,
    input logic            s_rready,
    input logic [NREG-1:0] frame_busy_i,
    input logic [NREG-1:0] pipe_empty_i,
    input logic [NREG-1:0] cfg_done_i,
    input logic [NREG-1:0] run_o,
    input logic [NREG-1:0] hold_o,
    input logic [NREG-1:0] load_rdy_o,
    input logic [NREG-1:0] rrst_o,
    input logic [NREG-1:0] start_o
);
    p_bhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);
    p_rhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> s_rvalid);

    for (genvar r = 0; r < NREG; r++) begin : g_chk
        logic [7:0] rlen_q;
        always_ff @(posedge clk) begin
            if (!rst_n)             rlen_q <= '0;
            else if (!rrst_o[r])    rlen_q <= '0;
            else if (rlen_q != 8'hFF) rlen_q <= rlen_q + 8'd1;
        end

        p_drain_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            hold_o[r] |-> (run_o[r] && !load_rdy_o[r]));
        p_ready_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(load_rdy_o[r]) |-> $past(hold_o[r] && !frame_busy_i[r] && pipe_empty_i[r]));
        p_reload_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (load_rdy_o[r] && cfg_done_i[r]) |=> (rrst_o[r] && !load_rdy_o[r]));
        p_quiet_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (load_rdy_o[r] || rrst_o[r]) |-> !run_o[r]);
        p_min_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rrst_o[r]) |-> (rlen_q >= 8'd4));
        p_auto_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rrst_o[r]) |-> (start_o[r] && run_o[r]));
        p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[r] |=> !start_o[r]);
    end
endmodule

bind prr_ctrl prr_ctrl_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_rvalid(s_rvalid), .s_rready(s_rready),
    .frame_busy_i(frame_busy_i), .pipe_empty_i(pipe_empty_i), .cfg_done_i(cfg_done_i),
    .run_o(run_o), .hold_o(hold_o), .load_rdy_o(load_rdy_o),
    .rrst_o(rrst_o), .start_o(start_o)
);

// File: tb/sim_prr_ctrl.sv
`timescale 1ns/1ps
module sim_prr_ctrl;
    localparam int NREG = 8;
    localparam int AW   = 12;
    localparam int DW   = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
    logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
    logic s_bready = 1, s_rready = 1;
    logic [DW-1:0] s_wdata = '0;
    logic [3:0] s_wstrb = '0;
    logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0] s_bresp, s_rresp;
    logic [DW-1:0] s_rdata;
    logic [NREG-1:0] frame_busy_i = '0, pipe_empty_i = '1, cfg_done_i = '0;
    logic [NREG-1:0] run_o, hold_o, load_rdy_o, rrst_o, start_o, irq_o;
    logic [NREG*3*DW-1:0] arg_o;

    prr_ctrl #(.NREG(NREG), .AW(AW), .DW(DW)) u0 (.*);

    int nchk = 0, nfail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] dat,
                      input logic [3:0] st, output logic [1:0] resp);
        @(negedge clk);
        s_awaddr = a; s_wdata = dat; s_wstrb = st; s_awvalid = 1; s_wvalid = 1;
        @(posedge clk);
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        resp = s_bresp;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] dat, output logic [1:0] resp);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1;
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 0;
        dat = s_rdata; resp = s_rresp;
    endtask

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [3:0]  strb;
        logic [31:0] data;
        logic [31:0] exp;
        logic [1:0]  resp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 4'h0, 32'h0,        32'h0,        2'b00, 4'd1},  // R1 state idle
        '{1'b0, 12'h004, 4'h0, 32'h0,        32'h4,        2'b00, 4'd1},  // R1 status
        '{1'b0, 12'h00C, 4'h0, 32'h0,        32'h0,        2'b00, 4'd1},  // R1 delay
        '{1'b0, 12'h008, 4'h0, 32'h0,        32'h0,        2'b00, 4'd1},  // R1 irq
        '{1'b1, 12'h010, 4'hF, 32'hA5A50001, 32'h0,        2'b00, 4'd2},  // R2
        '{1'b0, 12'h010, 4'h0, 32'h0,        32'hA5A50001, 2'b00, 4'd2},
        '{1'b1, 12'h034, 4'hF, 32'h12345678, 32'h0,        2'b00, 4'd2},
        '{1'b0, 12'h034, 4'h0, 32'h0,        32'h12345678, 2'b00, 4'd2},
        '{1'b0, 12'h014, 4'h0, 32'h0,        32'h0,        2'b00, 4'd11}, // R11
        '{1'b0, 12'h01C, 4'h0, 32'h0,        32'h0,        2'b10, 4'd3},  // R3 word 7
        '{1'b1, 12'h01C, 4'hF, 32'hFFFFFFFF, 32'h0,        2'b10, 4'd3},
        '{1'b0, 12'h100, 4'h0, 32'h0,        32'h0,        2'b10, 4'd3},  // R3 upper bits
        '{1'b1, 12'h012, 4'hF, 32'hFFFFFFFF, 32'h0,        2'b10, 4'd3},  // R3 misaligned
        '{1'b1, 12'h010, 4'h1, 32'h000000FF, 32'h0,        2'b00, 4'd2},  // R2 strobe
        '{1'b0, 12'h010, 4'h0, 32'h0,        32'hA5A500FF, 2'b00, 4'd2},
        '{1'b1, 12'h0EC, 4'hF, 32'h6,        32'h0,        2'b00, 4'd7},  // R7 delay reg
        '{1'b0, 12'h0EC, 4'h0, 32'h0,        32'h6,        2'b00, 4'd7}
    };

    initial begin
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [1:0] rs;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: outputs after reset
        chk("R1 run", 32'(run_o), 0);
        chk("R1 load_rdy", 32'(load_rdy_o | rrst_o | hold_o), 0);
        chk("R1 irq/start", 32'(irq_o | start_o), 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                wr(VEC[i].addr, VEC[i].data, VEC[i].strb, rs);
                chk($sformatf("R%0d table bresp %0d", VEC[i].req, i), 32'(rs), 32'(VEC[i].resp));
            end else begin
                rd(VEC[i].addr, rv, rs);
                chk($sformatf("R%0d table rdata %0d", VEC[i].req, i), rv, VEC[i].exp);
                chk($sformatf("R%0d table rresp %0d", VEC[i].req, i), 32'(rs), 32'(VEC[i].resp));
            end
        end
        chk("R2 arg_o r0a0", arg_o[0 +: 32], 32'hA5A500FF);
        chk("R2 arg_o r1a1", arg_o[(1*3+1)*32 +: 32], 32'h12345678);

        // R4 start
        wr(12'h000, 32'h1, 4'hF, rs);
        chk("R4 start pulse", 32'(start_o[0]), 1);
        chk("R4 run", 32'(run_o[0]), 1);
        @(negedge clk);
        chk("R4 pulse width", 32'(start_o[0]), 0);
        rd(12'h000, rv, rs);
        chk("R4 state", rv, 1);

        // R9 illegal start in running
        wr(12'h000, 32'h1, 4'hF, rs);
        rd(12'h000, rv, rs);
        chk("R9 state kept", rv, 1);
        rd(12'h004, rv, rs);
        chk("R9 illegal flag", rv, 32'h5);
        rd(12'h008, rv, rs);
        chk("R9 err event", rv, 32'h4);
        chk("R10 irq masked", 32'(irq_o[0]), 0);
        wr(12'h008, 32'h100, 4'hF, rs);
        chk("R10 irq enabled", 32'(irq_o[0]), 1);
        wr(12'h008, 32'h104, 4'hF, rs);
        chk("R10 irq cleared", 32'(irq_o[0]), 0);
        rd(12'h008, rv, rs);
        chk("R10 w1c keeps enable", rv, 32'h100);
        wr(12'h004, 32'h1, 4'hF, rs);
        rd(12'h004, rv, rs);
        chk("R10 illegal w1c", rv, 32'h4);

        // R5 drain gating
        frame_busy_i[0] = 1;
        wr(12'h000, 32'h2, 4'hF, rs);
        repeat (5) @(negedge clk);
        chk("R5 hold", 32'(hold_o[0]), 1);
        chk("R5 run in drain", 32'(run_o[0]), 1);
        chk("R5 not ready busy", 32'(load_rdy_o[0]), 0);
        pipe_empty_i[0] = 0; frame_busy_i[0] = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 not ready pipe full", 32'(load_rdy_o[0]), 0);
        pipe_empty_i[0] = 1;
        @(negedge clk);
        chk("R6 load_rdy", 32'(load_rdy_o[0]), 1);
        chk("R7 run off in reconfig", 32'(run_o[0]), 0);
        chk("R6 irq ready", 32'(irq_o[0]), 1);

        // R7 default reset length
        cfg_done_i[0] = 1;
        @(negedge clk);
        cfg_done_i[0] = 0;
        n = 0;
        while (rrst_o[0] && n < 100) begin
            if (run_o[0]) chk("R7 run off in reset", 32'(run_o[0]), 0);
            n++;
            @(negedge clk);
        end
        chk("R7 min reset len", n, 4);
        chk("R8 auto start", 32'(start_o[0]), 1);
        chk("R8 run active", 32'(run_o[0]), 1);
        rd(12'h008, rv, rs);
        chk("R8 events", rv, 32'h103);
        wr(12'h008, 32'h103, 4'hF, rs);
        chk("R10 irq low", 32'(irq_o[0]), 0);
        rd(12'h000, rv, rs);
        chk("R8 state active", rv, 5);

        // R7 programmed reset length
        wr(12'h00C, 32'h6, 4'hF, rs);
        wr(12'h000, 32'h2, 4'hF, rs);
        n = 0;
        while (!load_rdy_o[0] && n < 20) begin n++; @(negedge clk); end
        chk("R6 quick drain", 32'(load_rdy_o[0]), 1);
        wr(12'h000, 32'h1, 4'hF, rs);
        rd(12'h000, rv, rs);
        chk("R9 no cmd in reconfig", rv, 3);
        rd(12'h004, rv, rs);
        chk("R9 flag in reconfig", rv, 32'h5);
        cfg_done_i[0] = 1;
        @(negedge clk);
        cfg_done_i[0] = 0;
        n = 0;
        while (rrst_o[0] && n < 100) begin n++; @(negedge clk); end
        chk("R7 reset len 6", n, 6);

        // R12 stop, R9 stop in idle and multi-bit
        wr(12'h000, 32'h4, 4'hF, rs);
        chk("R12 run low", 32'(run_o[0]), 0);
        rd(12'h000, rv, rs);
        chk("R12 idle", rv, 0);
        wr(12'h004, 32'h1, 4'hF, rs);
        wr(12'h000, 32'h4, 4'hF, rs);
        rd(12'h004, rv, rs);
        chk("R9 stop in idle", rv, 32'h5);
        wr(12'h004, 32'h1, 4'hF, rs);
        wr(12'h000, 32'h3, 4'hF, rs);
        rd(12'h000, rv, rs);
        chk("R9 multi-bit state", rv, 0);
        rd(12'h004, rv, rs);
        chk("R9 multi-bit flag", rv, 32'h5);

        // R11 other regions untouched
        chk("R11 others idle", 32'(run_o[NREG-1:1] | rrst_o[NREG-1:1]), 0);
        rd(12'h020, rv, rs);
        chk("R11 region1 state", rv, 0);
        rd(12'h028, rv, rs);
        chk("R11 region1 events", rv, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule